// File: doc/BRIEF.md
# Three-Port Register File with Constant-Zero Entry

This block holds the general-purpose registers of a load/store processor core. It provides two independent read ports that answer without a clock edge, so the operand-fetch stage can obtain both source operands in the same cycle. A single write port stores a result on the rising clock edge, but only while its enable is high.

Entry 0 is wired to the constant zero. Both read ports return zero for it, and a write aimed at it is dropped. There is no bypass path. A read of the entry that is being written in the same cycle returns the old contents until the edge has passed. A synchronous active-high reset clears every writable entry.

Top module: `regfile3p`

## Requirements
- R1: The file has 32 entries of 32 bits, addressed by 5-bit numbers. When `wr_en` is 1 at a rising edge, `wr_data` is stored into entry `wr_addr` and can then be read from either port.
- R2: The two read ports are independent. Different addresses on `rd_addr_a` and `rd_addr_b` return the contents of their own entries in the same cycle.
- R3: Reads are combinational. A change on a read address changes the matching read data within the same cycle, with no clock edge in between.
- R4: When `wr_en` is 0 at a rising edge, no entry changes, whatever `wr_addr` and `wr_data` hold.
- R5: Address 0 returns 0 on both read ports at all times.
- R6: A write with `wr_addr` equal to 0 has no effect. Entry 0 still reads 0, and no other entry changes.
- R7: When `rst` is 1 at a rising edge, entries 1 to 31 become 0. Reset takes priority over a write in the same cycle.
- R8: When a read address equals `wr_addr` during an enabled write, that port shows the old value until the rising edge, and the new value after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset take effect on the rising edge |
| rst | input | 1 | Synchronous active-high clear of entries 1 to 31 |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Entry number to write |
| wr_data | input | 32 | Value to store |
| rd_addr_a | input | 5 | Entry number for read port A |
| rd_data_a | output | 32 | Contents of the entry selected on port A |
| rd_addr_b | input | 5 | Entry number for read port B |
| rd_data_b | output | 32 | Contents of the entry selected on port B |

## Verification
Four properties are checked on every cycle: address 0 reads zero on both ports; a value written to a nonzero entry appears on a port that reads that entry one cycle later; data stays steady when no write occurs and the address does not move; and both ports read zero right after a reset cycle. Other behaviour can only be shown by the bench's directed scenarios. These cover the combinational response to an address change within a cycle, the old value on a port that reads an entry during its write, reset winning over a write in the same cycle, and a write to entry 0 leaving the other entries alone. A sequence of random writes, some aimed at entry 0, is compared against a reference array on both ports.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_ENTRIES = 32;
  localparam int unsigned RF_BITS    = 32;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  output logic [DEPTH-1:0] wr_sel
);
  // one-hot strobe; entry 0 never selected
  always_comb begin
    wr_sel = '0;
    if (wr_en && (wr_addr != '0)) wr_sel[wr_addr] = 1'b1;
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [DEPTH-1:0]            wr_sel,
  input  logic [WIDTH-1:0]            wr_data,
  output logic [DEPTH-1:0][WIDTH-1:0] cells
);
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    if (gi == 0) begin : g_zero
      assign cells[gi] = '0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)             cells[gi] <= '0;
        else if (wr_sel[gi]) cells[gi] <= wr_data;
      end
    end
  end
  // wr_sel[0] is never set by the decoder; storage ignores it
  logic unused_sel0;
  assign unused_sel0 = wr_sel[0];
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] cells,
  input  logic [AW-1:0]               addr,
  output logic [WIDTH-1:0]            data
);
  assign data = cells[addr];
endmodule

// File: rtl/regfile3p.sv
module regfile3p #(
  parameter int unsigned DEPTH = rf_pkg::RF_ENTRIES,
  parameter int unsigned WIDTH = rf_pkg::RF_BITS,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr_a,
  output logic [WIDTH-1:0] rd_data_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_b
);
  logic [DEPTH-1:0]            wr_sel;
  logic [DEPTH-1:0][WIDTH-1:0] cells;

  rf_wr_decode #(.DEPTH(DEPTH), .AW(AW)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_sel(wr_sel)
  );

  rf_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wr_data(wr_data), .cells(cells)
  );

  rf_read_port #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_rpa (
    .cells(cells), .addr(rd_addr_a), .data(rd_data_a)
  );

  rf_read_port #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_rpb (
    .cells(cells), .addr(rd_addr_b), .data(rd_data_b)
  );
endmodule

// File: rtl/regfile3p_chk.sv
module regfile3p_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AW    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [AW-1:0]    rd_addr_a,
  input logic [WIDTH-1:0] rd_data_a,
  input logic [AW-1:0]    rd_addr_b,
  input logic [WIDTH-1:0] rd_data_b
);
  a_r5_zero_port_a: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |-> (rd_data_a == '0));
  a_r5_zero_port_b: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == '0) |-> (rd_data_b == '0));

  a_r1_write_visible_a: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst) && ($past(wr_addr) != '0) && (rd_addr_a == $past(wr_addr)))
      |-> (rd_data_a == $past(wr_data)));
  a_r2_write_visible_b: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst) && ($past(wr_addr) != '0) && (rd_addr_b == $past(wr_addr)))
      |-> (rd_data_b == $past(wr_data)));

  a_r4_hold_a: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst) && $stable(rd_addr_a)) |-> $stable(rd_data_a));

  a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((rd_data_a == '0) && (rd_data_b == '0)));
endmodule

bind regfile3p regfile3p_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
  .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
);

// File: tb/test_regfile3p.sv
module test_regfile3p;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr_a = '0;
  logic [31:0] rd_data_a;
  logic [4:0]  rd_addr_b = '0;
  logic [31:0] rd_data_b;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [32];

  always #2 clk = ~clk;  // 250 MHz

  regfile3p i_regfile3p (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one enabled/disabled write cycle, stimulus at the falling edge
  task automatic wcycle(input logic en, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (en && a != 0) mdl[a] = d;
  endtask

  task automatic rd2(input string req, input logic [4:0] a, input logic [4:0] b);
    rd_addr_a = a; rd_addr_b = b;
    #1;
    check({req, " port A"}, rd_data_a, mdl[a]);
    check({req, " port B"}, rd_data_b, mdl[b]);
  endtask

  task automatic t_reset_state();
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    @(negedge clk);
    for (int i = 0; i < 32; i++) rd2("R7 reset state", 5'(i), 5'(31 - i));
  endtask

  task automatic t_write_read();
    wcycle(1'b1, 5'd1, 32'h1234_5678);
    wcycle(1'b1, 5'd31, 32'hFFFF_FFFF);
    wcycle(1'b1, 5'd16, 32'h8000_0001);
    rd2("R1 write then read", 5'd1, 5'd31);
    rd2("R1 write then read", 5'd16, 5'd16);
  endtask

  task automatic t_dual_read();
    wcycle(1'b1, 5'd5, 32'hAAAA_5555);
    wcycle(1'b1, 5'd6, 32'h5555_AAAA);
    rd2("R2 independent ports", 5'd5, 5'd6);
    rd2("R2 independent ports", 5'd6, 5'd5);
  endtask

  task automatic t_comb_read();
    @(negedge clk);
    rd_addr_a = 5'd5; #0.5;
    check("R3 comb read", rd_data_a, 32'hAAAA_5555);
    rd_addr_a = 5'd6; #0.5;
    check("R3 comb read same cycle", rd_data_a, 32'h5555_AAAA);
  endtask

  task automatic t_no_enable();
    wcycle(1'b0, 5'd5, 32'hDEAD_BEEF);
    rd2("R4 disabled write", 5'd5, 5'd6);
  endtask

  task automatic t_zero_reg();
    wcycle(1'b1, 5'd0, 32'hCAFE_F00D);
    rd2("R6 write to zero", 5'd0, 5'd1);
    rd2("R5 zero reads", 5'd0, 5'd0);
    rd2("R6 others unchanged", 5'd5, 5'd31);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd16; wr_data = 32'h0BAD_F00D;
    rd_addr_a = 5'd16; rd_addr_b = 5'd16;
    #1;
    check("R8 old value before edge A", rd_data_a, 32'h8000_0001);
    check("R8 old value before edge B", rd_data_b, 32'h8000_0001);
    @(negedge clk);
    wr_en = 1'b0;
    mdl[16] = 32'h0BAD_F00D;
    #1;
    check("R8 new value after edge", rd_data_a, 32'h0BAD_F00D);
  endtask

  task automatic t_reset_priority();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'h1357_9BDF;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    rd2("R7 reset beats write", 5'd9, 5'd1);
    rd2("R7 reset clears", 5'd31, 5'd16);
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      logic [4:0] a;
      a = 5'($urandom_range(0, 31));
      if (n % 7 == 0) a = 5'd0;
      wcycle(($urandom_range(0, 3) != 0), a, $urandom);
      rd2("R1 random vs model", 5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)));
    end
    for (int i = 0; i < 32; i++) rd2("R2 random sweep", 5'(i), 5'(i ^ 5'h15));
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_write_read();
    t_dual_read();
    t_comb_read();
    t_no_enable();
    t_zero_reg();
    t_same_cycle();
    t_reset_priority();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule